// File: doc/BRIEF.md
# Vertex Memory FIFO Access Bridge

This block sits between a shader processor and a word-addressed vertex memory. Two four-entry queues carry traffic, one in each direction. The processor pushes 33-bit entries into the outbound queue: a 32-bit word plus a tag bit. The tag marks the word as either a setup command or a data word. Setup commands act only when they reach the head of the outbound queue, so they stay in order with the data words around them.

A read setup loads the read engine with a start offset and a word count. From then on the engine fetches consecutive words from vertex memory into the inbound queue by itself, and the processor pops them at its own pace. A later read setup replaces whatever the previous one had not yet fetched. A write setup loads a write pointer. Each data word that leaves the outbound queue is stored at that pointer, and the pointer then advances by one.

Both processor-facing streams use valid/ready. A push happens only on a cycle where `wr_valid` and `wr_ready` are both high. A pop happens only on a cycle where `rd_valid` and `rd_ready` are both high. `wr_ready` drops when the outbound queue is full. `rd_valid` drops when the inbound queue is empty. The memory port is a plain single-cycle synchronous RAM interface that handles one request per cycle. Read data returns on the cycle after the request.

Top module: `vtx_mem_bridge`

## Requirements
- R1: After reset, `wr_ready` is high, `rd_valid` is low, and `mem_req` stays low until a valid setup has left the outbound queue.
- R2: The outbound queue holds four entries. When it is full, `wr_ready` is low and no push occurs.
- R3: A setup takes effect only when it leaves the outbound queue. Data words queued ahead of it are handled under the earlier configuration.
- R4: `rd_valid` is low whenever the inbound queue is empty. The read engine never fetches more words than the inbound queue has room for. It stalls when the queue is full and resumes at the next address after a pop.
- R5: In a read setup, bits 23:20 give the word count, where 0 means 16. Bits 7:0 give the start offset. Exactly that many consecutive words, starting at the offset, are delivered in address order.
- R6: Bit 31 selects the setup kind: 1 means read, 0 means write. Bits 15:8 must equal 0x1A, and a setup with any other value there is discarded with no effect. No memory read happens before a valid read setup.
- R7: A read setup that leaves the outbound queue while words of an earlier read setup are still unfetched replaces that setup. Words already in the inbound queue are still delivered, and the unfetched remainder is never delivered.
- R8: A write setup sets the write pointer from bits 7:0. Each data word leaving the outbound queue is written at the pointer, and the pointer then increments by one. Data words that leave before any write setup are dropped and write nothing.
- R9: While the current read setup still has unfetched words, data words wait at the head of the outbound queue, because reads have priority. Only one memory request is made per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Processor offers an outbound entry |
| wr_ready | output | 1 | Outbound queue can accept an entry |
| wr_data | input | 32 | Outbound word |
| wr_is_setup | input | 1 | Tag: 1 means setup command, 0 means data word |
| rd_valid | output | 1 | Inbound queue holds a word |
| rd_ready | input | 1 | Processor takes the inbound word |
| rd_data | output | 32 | Inbound word |
| mem_req | output | 1 | Memory request this cycle |
| mem_we | output | 1 | 1 means write, 0 means read |
| mem_addr | output | 8 | Memory word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |

## Verification
The bench sweeps every count encoding, including 0 meaning 16. A decoder that took 0 literally, or that was off by one at the end of a run, would deliver the wrong number of words. It replaces a running fill while the inbound queue is full. A design that applied the new setup too early would lose buffered words, and one that applied it too late would leak old words after them. It queues a read setup behind stalled data words, which a design that decoded setups on push would act on early. It also pushes data and a malformed setup before any valid setup, which a design lacking the unconfigured guard would write to address 0 or read from.

// File: rtl/vmb_pkg.sv
package vmb_pkg;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 8;
  localparam int CNT_W    = 5;
  localparam int KIND_BIT = 31;
  localparam logic [7:0] MODE_VAL = 8'h1A;

  typedef struct packed {
    logic              is_read;
    logic              mode_ok;
    logic [CNT_W-1:0]  count;
    logic [ADDR_W-1:0] offset;
  } setup_t;

  function automatic setup_t decode_setup(input logic [DATA_W-1:0] w);
    setup_t s;
    s.is_read = w[KIND_BIT];
    s.mode_ok = (w[15:8] == MODE_VAL);
    s.count   = (w[23:20] == 4'd0) ? CNT_W'(16) : {1'b0, w[23:20]};
    s.offset  = w[ADDR_W-1:0];
    return s;
  endfunction
endpackage

// File: rtl/vmb_fifo.sv
module vmb_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [W-1:0]  in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [W-1:0]  out_data,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign in_ready  = (count != CW'(DEPTH));
  assign out_valid = (count != '0);
  assign out_data  = mem[rp];
  assign do_push   = in_valid && in_ready;
  assign do_pop    = out_valid && out_ready;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) begin
        mem[wp] <= in_data;
        wp      <= bump(wp);
      end
      if (do_pop) rp <= bump(rp);
      if (do_push && !do_pop)      count <= count + 1'b1;
      else if (do_pop && !do_push) count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/vmb_read_eng.sv
module vmb_read_eng
  import vmb_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [CNT_W-1:0]  ld_cnt,
  input  logic [CW-1:0]     q_count,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              fill_pend,
  output logic [CNT_W-1:0]  left
);
  logic [CW:0] occupied;

  assign occupied = {1'b0, q_count} + {{CW{1'b0}}, fill_pend};
  assign rd_req   = (left != '0) && (occupied < (CW + 1)'(DEPTH)) && !load;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_addr   <= '0;
      left      <= '0;
      fill_pend <= 1'b0;
    end else begin
      fill_pend <= rd_req;
      if (load) begin
        rd_addr <= ld_addr;
        left    <= ld_cnt;
      end else if (rd_req) begin
        rd_addr <= rd_addr + 1'b1;
        left    <= left - 1'b1;
      end
    end
  end
endmodule

// File: rtl/vmb_write_eng.sv
module vmb_write_eng
  import vmb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic              data_avail,
  input  logic              rd_busy,
  output logic              wr_req,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              data_take
);
  logic cfg_ok;

  assign wr_req    = data_avail && cfg_ok && !rd_busy;
  assign data_take = data_avail && (!cfg_ok || !rd_busy);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_ok  <= 1'b0;
      wr_addr <= '0;
    end else if (load) begin
      cfg_ok  <= 1'b1;
      wr_addr <= ld_addr;
    end else if (wr_req) begin
      wr_addr <= wr_addr + 1'b1;
    end
  end
endmodule

// File: rtl/vtx_mem_bridge.sv
module vtx_mem_bridge
  import vmb_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_is_setup,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);
  logic [DATA_W:0]   head;
  logic              head_valid, head_take;
  logic [CW-1:0]     wf_count, rf_count;
  logic              head_setup;
  setup_t            dec;
  logic              rsetup_fire, wsetup_fire;
  logic              rd_req, fill_pend, rf_in_ready, rf_push;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [CNT_W-1:0]  rd_left;
  logic              wr_req, data_take;

  vmb_fifo #(.W(DATA_W + 1), .DEPTH(DEPTH)) u_wq (
    .clk(clk), .rst_n(rst_n),
    .in_valid(wr_valid), .in_ready(wr_ready), .in_data({wr_is_setup, wr_data}),
    .out_valid(head_valid), .out_ready(head_take), .out_data(head),
    .count(wf_count)
  );

  assign head_setup  = head[DATA_W];
  assign dec         = decode_setup(head[DATA_W-1:0]);
  assign rsetup_fire = head_valid && head_setup && dec.mode_ok && dec.is_read;
  assign wsetup_fire = head_valid && head_setup && dec.mode_ok && !dec.is_read;
  assign head_take   = head_valid && (head_setup || data_take);

  vmb_read_eng #(.DEPTH(DEPTH)) u_rd (
    .clk(clk), .rst_n(rst_n),
    .load(rsetup_fire), .ld_addr(dec.offset), .ld_cnt(dec.count),
    .q_count(rf_count), .rd_req(rd_req), .rd_addr(rd_addr),
    .fill_pend(fill_pend), .left(rd_left)
  );

  vmb_write_eng u_wr (
    .clk(clk), .rst_n(rst_n),
    .load(wsetup_fire), .ld_addr(dec.offset),
    .data_avail(head_valid && !head_setup), .rd_busy(rd_left != '0),
    .wr_req(wr_req), .wr_addr(wr_addr), .data_take(data_take)
  );

  assign rf_push = fill_pend && rf_in_ready;

  vmb_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_rq (
    .clk(clk), .rst_n(rst_n),
    .in_valid(rf_push), .in_ready(rf_in_ready), .in_data(mem_rdata),
    .out_valid(rd_valid), .out_ready(rd_ready), .out_data(rd_data),
    .count(rf_count)
  );

  assign mem_req   = rd_req || wr_req;
  assign mem_we    = wr_req;
  assign mem_addr  = wr_req ? wr_addr : rd_addr;
  assign mem_wdata = head[DATA_W-1:0];
endmodule

// File: rtl/vtx_mem_bridge_chk.sv
module vtx_mem_bridge_chk
  import vmb_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_ready,
  input logic             rd_valid,
  input logic             mem_req,
  input logic             mem_we,
  input logic [CW-1:0]    wf_count,
  input logic [CW-1:0]    rf_count,
  input logic             fill_pend,
  input logic             rf_push,
  input logic [CNT_W-1:0] rd_left,
  input logic [CNT_W-1:0] setup_cnt,
  input logic             rsetup_fire,
  input logic             wsetup_fire
);
  logic seen_rd, seen_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_rd <= 1'b0;
      seen_wr <= 1'b0;
    end else begin
      seen_rd <= seen_rd || rsetup_fire;
      seen_wr <= seen_wr || wsetup_fire;
    end
  end

  AST_WQ_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (wf_count == CW'(DEPTH)) |-> !wr_ready); // R2
  AST_EMPTY_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_count == '0) |-> !rd_valid); // R4
  AST_NO_OVERFILL: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, rf_count} + {{CW{1'b0}}, fill_pend}) <= (CW + 1)'(DEPTH)); // R4
  AST_FILL_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |=> rf_push); // R4
  AST_NO_READ_UNSET: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> seen_rd); // R6
  AST_NO_WRITE_UNSET: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> seen_wr); // R8
  AST_SETUP_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    rsetup_fire |=> (rd_left == $past(setup_cnt))); // R7
  AST_READ_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (rd_left == '0)); // R9
endmodule

bind vtx_mem_bridge vtx_mem_bridge_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_ready(wr_ready), .rd_valid(rd_valid),
  .mem_req(mem_req), .mem_we(mem_we), .wf_count(wf_count), .rf_count(rf_count),
  .fill_pend(fill_pend), .rf_push(rf_push), .rd_left(rd_left),
  .setup_cnt(dec.count), .rsetup_fire(rsetup_fire), .wsetup_fire(wsetup_fire)
);

// File: tb/vtx_mem_bridge_tb.sv
`timescale 1ns/1ps
module vtx_mem_bridge_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0, wr_is_setup = 1'b0, rd_ready = 1'b0;
  logic [31:0] wr_data = '0;
  logic        wr_ready, rd_valid, mem_req, mem_we;
  logic [31:0] rd_data, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic [7:0]  mem_addr;
  logic [31:0] mem [256];
  logic [31:0] exp_mem [256];
  int errors = 0, checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  vtx_mem_bridge u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .wr_is_setup(wr_is_setup), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_data(rd_data), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always @(posedge clk)
    if (mem_req) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      else        mem_rdata     <= mem[mem_addr];
    end

  function automatic logic [31:0] init_val(int i);
    return 32'h5A00_0000 | (32'(i) << 12) | 32'(i ^ 8'hFF);
  endfunction
  function automatic logic [31:0] rsetup(logic [3:0] c, logic [7:0] off);
    return {1'b1, 7'd0, c, 4'd0, 8'h1A, off};
  endfunction
  function automatic logic [31:0] wsetup(logic [7:0] off);
    return {1'b0, 15'd0, 8'h1A, off};
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(logic [31:0] d, logic s);
    @(negedge clk);
    wr_valid = 1'b1; wr_data = d; wr_is_setup = s;
    while (!wr_ready) @(negedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic pop(output logic [31:0] v, output bit ok);
    int t = 0;
    @(negedge clk);
    rd_ready = 1'b1;
    while (!rd_valid && t < 300) begin @(negedge clk); t++; end
    ok = rd_valid;
    v  = rd_data;
    @(negedge clk);
    rd_ready = 1'b0;
  endtask

  task automatic expect_run(int base, int n, string req);
    logic [31:0] v; bit ok;
    for (int k = 0; k < n; k++) begin
      pop(v, ok);
      chk(ok && v == exp_mem[(base + k) & 255], req, v, exp_mem[(base + k) & 255]);
    end
  endtask

  task automatic expect_idle(string req);
    repeat (12) @(negedge clk);
    chk(!rd_valid, req, 32'(rd_valid), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v; bit ok; bit idle;
    for (int i = 0; i < 256; i++) begin mem[i] = init_val(i); exp_mem[i] = init_val(i); end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(wr_ready, "R1 wr_ready", 32'(wr_ready), 32'd1);
    chk(!rd_valid, "R1 rd_valid", 32'(rd_valid), 32'd0);
    idle = 1;
    for (int k = 0; k < 8; k++) begin @(negedge clk); if (mem_req) idle = 0; end
    chk(idle, "R1 mem_req idle", 32'(idle), 32'd1);

    // R8 data before any write setup is dropped; R6 bad mode ignored
    push(32'hDEAD_BEEF, 1'b0);
    push({1'b1, 7'd0, 4'd1, 4'd0, 8'h00, 8'h00}, 1'b1);
    expect_idle("R6 bad-mode read setup");
    push(rsetup(4'd1, 8'h00), 1'b1);
    expect_run(0, 1, "R8 dropped data left addr 0");
    expect_idle("R5 single word");

    // R7 replace pending fill while inbound queue is full
    push(rsetup(4'd0, 8'h10), 1'b1);
    repeat (20) @(negedge clk);
    push(rsetup(4'd3, 8'h80), 1'b1);
    repeat (10) @(negedge clk);
    expect_run(8'h10, 4, "R7 buffered old words kept");
    expect_run(8'h80, 3, "R7 new setup words");
    expect_idle("R7 old remainder abandoned");

    // R9 / R2 / R3: data waits behind read fill, queue fills, later setup deferred
    push(rsetup(4'd0, 8'h20), 1'b1);
    repeat (20) @(negedge clk);
    push(wsetup(8'h30), 1'b1);
    push(32'h1111_0000, 1'b0);
    push(32'h2222_0001, 1'b0);
    push(32'h3333_0002, 1'b0);
    push(rsetup(4'd2, 8'h30), 1'b1);
    @(negedge clk);
    chk(!wr_ready, "R2 outbound queue full", 32'(wr_ready), 32'd0);
    chk(mem[8'h30] == init_val(8'h30), "R9 write held during fill", mem[8'h30], init_val(8'h30));
    expect_run(8'h20, 16, "R3 earlier read setup runs to end");
    exp_mem[8'h30] = 32'h1111_0000;
    exp_mem[8'h31] = 32'h2222_0001;
    exp_mem[8'h32] = 32'h3333_0002;
    expect_run(8'h30, 2, "R3 queued read sees prior writes");
    expect_idle("R5 count two");
    push(rsetup(4'd1, 8'h32), 1'b1);
    expect_run(8'h32, 1, "R8 pointer increment");

    // R5 / R4 sweep of every count encoding
    for (int n = 1; n <= 16; n++) begin
      int off = (n * 13 + 5) & 255;
      push(rsetup(4'(n), 8'(off)), 1'b1);
      expect_run(off, n, "R5 count sweep");
      expect_idle("R5 exact length");
    end

    // R8 write sweep with wrap of address space
    push(wsetup(8'hFC), 1'b1);
    for (int k = 0; k < 6; k++) begin
      push(32'hC0DE_0000 + 32'(k), 1'b0);
      exp_mem[(8'hFC + k) & 255] = 32'hC0DE_0000 + 32'(k);
    end
    push(rsetup(4'd6, 8'hFC), 1'b1);
    expect_run(8'hFC, 6, "R8 written words read back");

    pop(v, ok);
    chk(!ok, "R4 pop from empty", 32'(ok), 32'd0);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule